// File: doc/BRIEF.md
# Tile Scatter Engine

This block moves the elements of a source tile into a destination tile. The position of each element in the destination comes from a companion index tile. The source and index tiles share one shape. The engine walks the valid sub-region of the source in row-major order. For each element it reads the data and its index in the same cycle. The index is treated as a linear element offset into destination storage, so a value of 7 means the eighth element of the destination buffer, not row 7. The data element is then written there unchanged.

A controller loads the tile base addresses, the valid row and column counts, the row pitch (the allocated column count) and an element-size code, then pulses `start`. The engine streams one element per cycle through its read and write ports and pulses `done` once the last write has landed. Index values are never range-checked. The destination address wraps at the memory size. When several elements target the same destination slot, the slot ends up holding the value of the element visited last.

Top module: `tscat_engine`

## Requirements
- R1: After reset, `busy`, `done`, `src_rd_en`, `idx_rd_en` and `dst_wr_en` are all low.
- R2: Once `start` is accepted, the engine visits only the valid region, in order: row 0 columns 0..cols-1, then row 1, and so on. Element (i, j) has linear offset off = i*pitch + j. Its source read address is src_base + off*E, where E is the element byte size. One source read and one index read are issued per cycle.
- R3: The size code `cfg_esz` selects the element size: 0 means 1 byte, 1 means 2 bytes, 2 (or 3) means 4 bytes. With 4-byte elements the index is 32 bits wide and is read at idx_base + off*4. With 1- or 2-byte elements the index is the low 16 bits read at idx_base + off*2.
- R4: The destination write address is dst_base + k*E, where k is the index value, taken modulo 2^ADDR_W. It is never compared with any bound, and k is never treated as a row number.
- R5: Each write carries the source element bits unchanged in the low E bytes of `dst_wr_data`. `dst_wr_strb` is 4'b0001, 4'b0011 or 4'b1111 for E = 1, 2 or 4.
- R6: Read data arrives one cycle after the read request. Each read pair produces exactly one destination write in the following cycle, so the writes keep the walk order.
- R7: When two elements target the same destination offset, the destination keeps the value of the element that comes later in the walk.
- R8: For a job of n > 0 elements, `done` is high for exactly one cycle. It rises n+1 clock edges after the edge that accepted `start`, that is, one cycle after the final write commits.
- R9: If the valid row count or the valid column count is zero, `done` pulses in the cycle right after the accepting edge, and no read or write is issued.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running job finishes with its own configuration and its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a job (accepted only when idle) |
| cfg_esz | input | 2 | Element size code: 0 = 1 B, 1 = 2 B, 2/3 = 4 B |
| cfg_src_base | input | ADDR_W | Source tile byte base address |
| cfg_idx_base | input | ADDR_W | Index tile byte base address |
| cfg_dst_base | input | ADDR_W | Destination tile byte base address |
| cfg_rows | input | DIM_W | Valid row count |
| cfg_cols | input | DIM_W | Valid column count |
| cfg_pitch | input | DIM_W | Allocated columns per row (row pitch in elements) |
| busy | output | 1 | A job is in flight |
| done | output | 1 | One-cycle pulse when the job completes |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | ADDR_W | Source read byte address |
| src_rd_data | input | 32 | Source read data, little-endian, one cycle after the request |
| idx_rd_en | output | 1 | Index read request |
| idx_rd_addr | output | ADDR_W | Index read byte address |
| idx_rd_data | input | 32 | Index read data, little-endian, one cycle after the request |
| dst_wr_en | output | 1 | Destination write |
| dst_wr_addr | output | ADDR_W | Destination write byte address |
| dst_wr_data | output | 32 | Destination write data |
| dst_wr_strb | output | 4 | Byte strobes, counted upward from `dst_wr_addr` |

## Verification
The bench sweeps every element size over all valid-region shapes up to 4x4 inside a wider pitch. It uses index patterns that collide heavily, so a design that wrote out of walk order, or that dropped or duplicated a write, leaves the wrong survivor in a slot. A design that walked the whole pitch instead of only the valid columns would show extra reads. A design that picked the wrong index width would pick up a neighbouring index half and scatter to the wrong place. Large index values check that the address wraps rather than being clamped or skipped. Zero-sized jobs and a `start` pulse injected mid-job check that no stray work happens and that the latency stays exactly n+1.

// File: rtl/tscat_pkg.sv
package tscat_pkg;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_B16 = 2'd1,
    ESZ_B32 = 2'd2,
    ESZ_RSV = 2'd3
  } esz_e;

  // log2 of the data element byte size
  function automatic logic [1:0] data_shift(input logic [1:0] esz);
    case (esz)
      ESZ_B8:  data_shift = 2'd0;
      ESZ_B16: data_shift = 2'd1;
      default: data_shift = 2'd2;
    endcase
  endfunction

  // log2 of the index element byte size: 32-bit data uses 32-bit indices
  function automatic logic [1:0] index_shift(input logic [1:0] esz);
    case (esz)
      ESZ_B8, ESZ_B16: index_shift = 2'd1;
      default:         index_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/tscat_scale.sv
module tscat_scale #(
  parameter int IN_W   = 12,
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IN_W-1:0]   val,
  input  logic [1:0]        sh,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = IN_W + 3;

  logic [EXT_W-1:0] ext;

  always_comb begin
    ext  = {3'b000, val} << sh;
    addr = base + ADDR_W'(ext);
  end
endmodule

// File: rtl/tscat_walker.sv
module tscat_walker
  import tscat_pkg::*;
#(
  parameter int DIM_W  = 6,
  parameter int ADDR_W = 10,
  localparam int OFF_W = 2 * DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy_i,
  input  logic [1:0]        cfg_esz,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_idx_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [DIM_W-1:0]  cfg_rows,
  input  logic [DIM_W-1:0]  cfg_cols,
  input  logic [DIM_W-1:0]  cfg_pitch,
  output logic              run_o,
  output logic [OFF_W-1:0]  iss_off,
  output logic              iss_last,
  output logic              zero_done,
  output logic [1:0]        job_esz,
  output logic [ADDR_W-1:0] job_src_base,
  output logic [ADDR_W-1:0] job_idx_base,
  output logic [ADDR_W-1:0] job_dst_base
);
  logic              run_q, run_d;
  logic [DIM_W-1:0]  row_q, row_d, col_q, col_d;
  logic [OFF_W-1:0]  rbase_q, rbase_d;
  logic [DIM_W-1:0]  vr_q, vc_q, pitch_q;
  logic [1:0]        esz_q;
  logic [ADDR_W-1:0] sb_q, ib_q, db_q;
  logic              accept, empty, row_end, last;

  always_comb begin
    accept  = start && !busy_i;
    empty   = (cfg_rows == '0) || (cfg_cols == '0);
    row_end = (col_q == vc_q - DIM_W'(1));
    last    = row_end && (row_q == vr_q - DIM_W'(1));

    run_d   = run_q;
    row_d   = row_q;
    col_d   = col_q;
    rbase_d = rbase_q;
    if (accept) begin
      run_d   = !empty;
      row_d   = '0;
      col_d   = '0;
      rbase_d = '0;
    end else if (run_q) begin
      if (last) begin
        run_d = 1'b0;
      end else if (row_end) begin
        col_d   = '0;
        row_d   = row_q + DIM_W'(1);
        rbase_d = rbase_q + OFF_W'(pitch_q);
      end else begin
        col_d = col_q + DIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      rbase_q <= '0;
    end else begin
      run_q   <= run_d;
      row_q   <= row_d;
      col_q   <= col_d;
      rbase_q <= rbase_d;
    end
  end

  // job configuration, captured only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vr_q    <= '0;
      vc_q    <= '0;
      pitch_q <= '0;
      esz_q   <= '0;
      sb_q    <= '0;
      ib_q    <= '0;
      db_q    <= '0;
    end else if (accept) begin
      vr_q    <= cfg_rows;
      vc_q    <= cfg_cols;
      pitch_q <= cfg_pitch;
      esz_q   <= cfg_esz;
      sb_q    <= cfg_src_base;
      ib_q    <= cfg_idx_base;
      db_q    <= cfg_dst_base;
    end
  end

  assign run_o        = run_q;
  assign iss_off      = rbase_q + OFF_W'(col_q);
  assign iss_last     = last;
  assign zero_done    = accept && empty;
  assign job_esz      = esz_q;
  assign job_src_base = sb_q;
  assign job_idx_base = ib_q;
  assign job_dst_base = db_q;
endmodule

// File: rtl/tscat_commit.sv
module tscat_commit
  import tscat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iss_valid,
  input  logic        iss_last,
  input  logic        zero_done,
  input  logic [1:0]  job_esz,
  input  logic [31:0] src_rd_data,
  input  logic [31:0] idx_rd_data,
  output logic        wr_valid,
  output logic [31:0] wr_index,
  output logic [31:0] wr_data,
  output logic [3:0]  wr_strb,
  output logic        done
);
  logic v1_q, v1_d, last1_q, last1_d, done_q, done_d;

  always_comb begin
    v1_d    = iss_valid;
    last1_d = iss_valid && iss_last;
    done_d  = (v1_q && last1_q) || zero_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      last1_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      v1_q    <= v1_d;
      last1_q <= last1_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    case (job_esz)
      ESZ_B8: begin
        wr_index = {16'h0000, idx_rd_data[15:0]};
        wr_data  = {24'h000000, src_rd_data[7:0]};
        wr_strb  = 4'b0001;
      end
      ESZ_B16: begin
        wr_index = {16'h0000, idx_rd_data[15:0]};
        wr_data  = {16'h0000, src_rd_data[15:0]};
        wr_strb  = 4'b0011;
      end
      default: begin
        wr_index = idx_rd_data;
        wr_data  = src_rd_data;
        wr_strb  = 4'b1111;
      end
    endcase
  end

  assign wr_valid = v1_q;
  assign done     = done_q;
endmodule

// File: rtl/tscat_engine.sv
module tscat_engine
  import tscat_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DIM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_esz,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_idx_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [DIM_W-1:0]  cfg_rows,
  input  logic [DIM_W-1:0]  cfg_cols,
  input  logic [DIM_W-1:0]  cfg_pitch,
  output logic              busy,
  output logic              done,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_rd_addr,
  input  logic [31:0]       src_rd_data,
  output logic              idx_rd_en,
  output logic [ADDR_W-1:0] idx_rd_addr,
  input  logic [31:0]       idx_rd_data,
  output logic              dst_wr_en,
  output logic [ADDR_W-1:0] dst_wr_addr,
  output logic [31:0]       dst_wr_data,
  output logic [3:0]        dst_wr_strb
);
  localparam int OFF_W = 2 * DIM_W;

  logic              run, iss_last, zero_done, wr_valid;
  logic [OFF_W-1:0]  iss_off;
  logic [1:0]        job_esz, sh_d, sh_i;
  logic [ADDR_W-1:0] job_sb, job_ib, job_db;
  logic [31:0]       wr_index;

  assign busy = run || wr_valid;
  assign sh_d = data_shift(job_esz);
  assign sh_i = index_shift(job_esz);

  tscat_walker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy_i(busy),
    .cfg_esz(cfg_esz), .cfg_src_base(cfg_src_base),
    .cfg_idx_base(cfg_idx_base), .cfg_dst_base(cfg_dst_base),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_pitch(cfg_pitch),
    .run_o(run), .iss_off(iss_off), .iss_last(iss_last),
    .zero_done(zero_done), .job_esz(job_esz),
    .job_src_base(job_sb), .job_idx_base(job_ib), .job_dst_base(job_db)
  );

  tscat_scale #(.IN_W(OFF_W), .ADDR_W(ADDR_W)) u_src_addr (
    .base(job_sb), .val(iss_off), .sh(sh_d), .addr(src_rd_addr)
  );

  tscat_scale #(.IN_W(OFF_W), .ADDR_W(ADDR_W)) u_idx_addr (
    .base(job_ib), .val(iss_off), .sh(sh_i), .addr(idx_rd_addr)
  );

  tscat_commit u_commit (
    .clk(clk), .rst_n(rst_n), .iss_valid(run), .iss_last(iss_last),
    .zero_done(zero_done), .job_esz(job_esz),
    .src_rd_data(src_rd_data), .idx_rd_data(idx_rd_data),
    .wr_valid(wr_valid), .wr_index(wr_index), .wr_data(dst_wr_data),
    .wr_strb(dst_wr_strb), .done(done)
  );

  tscat_scale #(.IN_W(32), .ADDR_W(ADDR_W)) u_dst_addr (
    .base(job_db), .val(wr_index), .sh(sh_d), .addr(dst_wr_addr)
  );

  assign src_rd_en = run;
  assign idx_rd_en = run;
  assign dst_wr_en = wr_valid;
endmodule

// File: rtl/tscat_engine_chk.sv
module tscat_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       src_rd_en,
  input logic       idx_rd_en,
  input logic       dst_wr_en,
  input logic [3:0] dst_wr_strb
);
  a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> $past(src_rd_en && idx_rd_en));

  a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |=> dst_wr_en);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(dst_wr_en) || $past(start && !busy)));

  a_r10_reads_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |-> busy);

  a_r5_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> (dst_wr_strb[0] && ($countones(dst_wr_strb) != 3)
                   && (dst_wr_strb[3] == dst_wr_strb[2])));
endmodule

bind tscat_engine tscat_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .src_rd_en(src_rd_en), .idx_rd_en(idx_rd_en), .dst_wr_en(dst_wr_en),
  .dst_wr_strb(dst_wr_strb)
);

// File: tb/tscat_engine_test.sv
`timescale 1ns/1ps
module tscat_engine_test;
  localparam int AW = 10;
  localparam int DW = 6;
  localparam int MSZ = 1 << AW;

  logic clk, rst_n, start;
  logic [1:0] cfg_esz;
  logic [AW-1:0] cfg_src_base, cfg_idx_base, cfg_dst_base;
  logic [DW-1:0] cfg_rows, cfg_cols, cfg_pitch;
  logic busy, done, src_rd_en, idx_rd_en, dst_wr_en;
  logic [AW-1:0] src_rd_addr, idx_rd_addr, dst_wr_addr;
  logic [31:0] src_rd_data, idx_rd_data, dst_wr_data;
  logic [3:0] dst_wr_strb;

  tscat_engine #(.ADDR_W(AW), .DIM_W(DW)) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] smem [MSZ];
  logic [7:0] imem [MSZ];
  logic [7:0] dmem [MSZ];
  logic [7:0] emem [MSZ];
  int rlog_s [256];
  int rlog_i [256];
  int n_rd, n_wr;
  int checks = 0, fails = 0;

  // memory models: one-cycle read latency, byte-strobed write
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < MSZ; a++) dmem[a] <= 8'h00;
      n_rd <= 0;
      n_wr <= 0;
    end else begin
      if (src_rd_en) begin
        src_rd_data <= {smem[(int'(src_rd_addr)+3)%MSZ], smem[(int'(src_rd_addr)+2)%MSZ],
                        smem[(int'(src_rd_addr)+1)%MSZ], smem[int'(src_rd_addr)]};
        rlog_s[n_rd%256] <= int'(src_rd_addr);
        rlog_i[n_rd%256] <= int'(idx_rd_addr);
        n_rd <= n_rd + 1;
      end
      if (idx_rd_en)
        idx_rd_data <= {imem[(int'(idx_rd_addr)+3)%MSZ], imem[(int'(idx_rd_addr)+2)%MSZ],
                        imem[(int'(idx_rd_addr)+1)%MSZ], imem[int'(idx_rd_addr)]};
      if (dst_wr_en) begin
        for (int b = 0; b < 4; b++)
          if (dst_wr_strb[b]) dmem[(int'(dst_wr_addr)+b)%MSZ] <= dst_wr_data[8*b +: 8];
        n_wr <= n_wr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_idx(input int addr, input int isz, input longint val);
    for (int b = 0; b < isz; b++) imem[(addr+b)%MSZ] = 8'((val >> (8*b)) & 255);
  endtask

  // pattern 0: k = (off*mul + add) % span ; pattern 1: large k that wraps
  task automatic fill_idx(input int esz, input int ib, input int n_off,
                          input int mul, input int add, input int span, input bit big);
    int isz = (esz == 2) ? 4 : 2;
    for (int o = 0; o < n_off; o++)
      if (big) put_idx(ib + o*isz, isz, (isz == 4) ? (64'h0001_2340 + o*5) : (64'hFFF0 - o));
      else     put_idx(ib + o*isz, isz, (o*mul + add) % span);
  endtask

  task automatic run_job(input int esz, input int sb, input int ib, input int db,
                         input int vr, input int vc, input int pt, input int glitch,
                         input string tag);
    int eb  = (esz == 0) ? 1 : (esz == 1) ? 2 : 4;
    int isz = (esz == 2) ? 4 : 2;
    int n   = vr * vc;
    int r0, w0, lat, mism, e, bad_s, bad_i;
    // reference: apply writes in row-major order
    for (int i = 0; i < vr; i++)
      for (int j = 0; j < vc; j++) begin
        int off = i*pt + j;
        int ia  = (ib + off*isz) % MSZ;
        longint k = imem[ia] | (longint'(imem[(ia+1)%MSZ]) << 8);
        int sa  = (sb + off*eb) % MSZ;
        int da;
        if (isz == 4) k = k | (longint'(imem[(ia+2)%MSZ]) << 16) | (longint'(imem[(ia+3)%MSZ]) << 24);
        da = int'((db + k*eb) % MSZ);
        for (int b = 0; b < eb; b++) emem[(da+b)%MSZ] = smem[(sa+b)%MSZ];
      end
    r0 = n_rd; w0 = n_wr;
    cfg_esz = 2'(esz); cfg_src_base = AW'(sb); cfg_idx_base = AW'(ib);
    cfg_dst_base = AW'(db); cfg_rows = DW'(vr); cfg_cols = DW'(vc); cfg_pitch = DW'(pt);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin
      if (glitch > 0 && lat == glitch) begin
        start = 1'b1; cfg_dst_base = AW'(db ^ 512); cfg_rows = DW'(1); cfg_cols = DW'(1);
      end else start = 1'b0;
      @(posedge clk); @(negedge clk);
      lat++;
    end
    start = 1'b0;
    @(negedge clk);
    chk(lat == ((n == 0) ? 0 : n + 1), (n == 0) ? "R9" : (glitch > 0 ? "R10" : "R8"),
        {tag, " done latency"}, lat, (n == 0) ? 0 : n + 1);
    chk(!done, "R8", {tag, " done pulse width"}, done, 0);
    chk(n_wr - w0 == n, "R6", {tag, " write count"}, n_wr - w0, n);
    chk(n_rd - r0 == n, "R2", {tag, " read count"}, n_rd - r0, n);
    e = 0; bad_s = -1; bad_i = -1;
    for (int i = 0; i < vr; i++)
      for (int j = 0; j < vc; j++) begin
        int off = i*pt + j;
        if (e < n_rd - r0) begin
          if (rlog_s[(r0+e)%256] != (sb + off*eb) % MSZ && bad_s < 0) bad_s = e;
          if (rlog_i[(r0+e)%256] != (ib + off*isz) % MSZ && bad_i < 0) bad_i = e;
        end
        e++;
      end
    chk(bad_s < 0, "R2", {tag, " source address order, first bad element"}, bad_s, -1);
    chk(bad_i < 0, "R3", {tag, " index address/width, first bad element"}, bad_i, -1);
    mism = 0;
    for (int a = 0; a < MSZ; a++) if (dmem[a] !== emem[a]) mism++;
    chk(mism == 0, (n == 0) ? "R9" : "R7", {tag, " destination contents (R4 R5) mismatching bytes"}, mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    cfg_esz = '0; cfg_src_base = '0; cfg_idx_base = '0; cfg_dst_base = '0;
    cfg_rows = '0; cfg_cols = '0; cfg_pitch = '0;
    for (int a = 0; a < MSZ; a++) begin
      smem[a] = 8'((a*37 + 11) & 255);
      imem[a] = 8'h00;
      emem[a] = 8'h00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    chk(!src_rd_en && !idx_rd_en && !dst_wr_en, "R1", "enables in reset",
        {src_rd_en, idx_rd_en, dst_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !dst_wr_en, "R1", "idle after reset", {busy, done, dst_wr_en}, 0);

    // sweep: every size, every region up to 4x4 in pitch 5
    for (int esz = 0; esz < 3; esz++)
      for (int vr = 1; vr <= 4; vr++)
        for (int vc = 1; vc <= 4; vc++) begin
          int combo = esz*16 + (vr-1)*4 + (vc-1);
          int span  = (combo % 3 == 0) ? 3 : 40;
          fill_idx(esz, 300, 5*vr, 1 + 2*(combo % 4), combo % 7, span, 1'b0);
          run_job(esz, 100 + 7*esz, 300, 600, vr, vc, 5, 0, $sformatf("sweep esz%0d %0dx%0d", esz, vr, vc));
        end

    // R7: all elements collide on one slot, the last one must survive
    fill_idx(2, 40, 12, 0, 9, 50, 1'b0);
    run_job(2, 500, 40, 700, 3, 4, 4, 0, "R7 full collision");
    // R4: large indices wrap modulo memory size, no bounds check
    fill_idx(2, 40, 12, 0, 0, 1, 1'b1);
    run_job(2, 20, 40, 800, 3, 4, 4, 0, "R4 wrap 32-bit index");
    fill_idx(1, 40, 12, 0, 0, 1, 1'b1);
    run_job(1, 20, 40, 800, 3, 4, 4, 0, "R4 wrap 16-bit index");
    fill_idx(0, 40, 12, 0, 0, 1, 1'b1);
    run_job(0, 1020, 40, 900, 3, 4, 4, 0, "R3 byte elements with wrapping source");
    // R9: empty regions
    run_job(2, 0, 40, 100, 0, 3, 4, 0, "R9 zero rows");
    run_job(0, 0, 40, 100, 2, 0, 4, 0, "R9 zero cols");
    // R10: start pulsed mid-job must be ignored
    fill_idx(1, 40, 16, 3, 1, 30, 1'b0);
    run_job(1, 200, 40, 64, 4, 4, 4, 3, "R10 start while busy");
    // back to back after the ignored pulse
    run_job(1, 200, 40, 64, 2, 2, 6, 0, "R8 job after ignored start");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule